// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

The block collects up to thirty-two interrupt lines, each sampled through a short synchronizer. Each line is set to one of two detection modes, edge or level, and to one of two active senses. Detected events latch into a pending register regardless of whether the line is enabled. Software removes latched events by writing ones. An enable register gates the pending bits into a masked view. A per-line routing bit sends each masked bit either to the critical request or to the normal request.

Software reaches the block through a flat register bus with a word address, separate read and write strobes, and 32-bit data. Writes are registered. Reads are combinational. A vector register names the lowest-numbered masked pending line. A spare configuration word is plain read/write storage.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the pending, enable, routing, mode and spare registers read zero, the sense register reads 0xFFFFFFFF (all active-high or rising), the vector reads 0xFFFFFFFF and both requests are low.
- R2: Line n (port bit `src_i[n]`) occupies bit 31-n of every per-line register, so line 0 is bit 31.
- R3: With mode bit 1 (edge), a pending bit sets on a rising input when the sense bit is 1 and on a falling input when it is 0. An input change ahead of clock edge k is visible in the pending bit after edge k+2.
- R4: With mode bit 0 (level), a pending bit sets while the input equals the sense bit. Writing a 1 to clear it has no lasting effect while the input stays active, whether the line is enabled or not.
- R5: Writing to the pending register (offset 0x0) clears the bits written as 1 and leaves the bits written as 0. Writing 0xFFFFFFFF clears every latched edge event.
- R6: Pending bits latch whatever the enable bits are. The masked register (offset 0x6) reads as pending AND enable.
- R7: `crit_o` is high when some masked bit has its routing bit (offset 0x3) at 1. `ncrit_o` is high when some masked bit has its routing bit at 0.
- R8: A write to the mode (offset 0x5) or sense (offset 0x4) register never creates an edge event by itself.
- R9: The vector register (offset 0x7) returns the number of the lowest-numbered line with a masked pending bit, or 0xFFFFFFFF when there is none.
- R10: The spare word (offset 0x8) reads back what was written. Writes to offsets 0x6 and 0x7 are ignored. Offsets that are not defined read zero. `rdata_o` is zero while `rd_i` is low.
- R11: A register write takes effect at the clock edge that samples `wr_i`. A read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt lines, bit n is line n |
| addr_i | input | 4 | Register word offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| crit_o | output | 1 | Critical request |
| ncrit_o | output | 1 | Non-critical request |

## Verification
The bench uses the defaults: 32 lines and a two-stage synchronizer. With these values every register bit maps to a line, and the fixed three-edge latency from an input change to the pending bit holds. That covers the extreme lines 0 and 31 of the priority encode and the full 0xFFFFFFFF clear. Sense flips, mode flips, held-active level lines on disabled inputs, and clears that collide with active levels all appear on this one configuration.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND = 4'h0,
    REG_EN   = 4'h2,
    REG_ROUT = 4'h3,
    REG_SNS  = 4'h4,
    REG_MODE = 4'h5,
    REG_MSK  = 4'h6,
    REG_VEC  = 4'h7,
    REG_SPR  = 4'h8
  } reg_addr_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic mode_i,   // 1 edge, 0 level
  input  logic sns_i,    // 1 rising/high, 0 falling/low
  input  logic clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic smp, prev_q, pend_q, active, edge_ev, set;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= smp;
      pend_q <= (pend_q & ~clr_i) | set;
    end
  end

  // edge compares sampled history only, so config writes cannot fake an event
  assign active  = (smp == sns_i);
  assign edge_ev = mode_i & (smp ^ prev_q) & active;
  assign set     = edge_ev | (~mode_i & active);
  assign pend_o  = pend_q;

  AST_LEVEL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && smp == sns_i) |=> pend_q); // R4
  AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && smp != prev_q && smp == sns_i) |=> pend_q); // R3
  AST_NO_FALSE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && smp == prev_q && !pend_q) |=> !pend_q); // R8
  AST_CLEAR_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && mode_i && smp == prev_q) |=> !pend_q); // R5
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] msk_i,
  output logic [NUM_SRC-1:0] vec_o
);
  // line n sits at bit NUM_SRC-1-n; the lowest line number wins
  always_comb begin
    vec_o = '1;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (msk_i[NUM_SRC-1-n]) vec_o = NUM_SRC'(n);
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               crit_o,
  output logic               ncrit_o
);
  logic [NUM_SRC-1:0] en_q, rout_q, sns_q, mode_q, spr_q;
  logic [NUM_SRC-1:0] pend, msk, vec, clr;
  logic               wr_pend;

  assign wr_pend = wr_i && (addr_i == REG_PEND);
  assign clr     = wr_pend ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rout_q <= '0;
      sns_q  <= '1;
      mode_q <= '0;
      spr_q  <= '0;
    end else if (wr_i) begin
      case (reg_addr_e'(addr_i))
        REG_EN:   en_q   <= wdata_i;
        REG_ROUT: rout_q <= wdata_i;
        REG_SNS:  sns_q  <= wdata_i;
        REG_MODE: mode_q <= wdata_i;
        REG_SPR:  spr_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int B = NUM_SRC - 1 - n;
    irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (src_i[n]),
      .mode_i (mode_q[B]),
      .sns_i  (sns_q[B]),
      .clr_i  (clr[B]),
      .pend_o (pend[B])
    );
  end

  assign msk     = pend & en_q;
  assign crit_o  = |(msk & rout_q);
  assign ncrit_o = |(msk & ~rout_q);

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .msk_i (msk),
    .vec_o (vec)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (reg_addr_e'(addr_i))
        REG_PEND: rdata_o = pend;
        REG_EN:   rdata_o = en_q;
        REG_ROUT: rdata_o = rout_q;
        REG_SNS:  rdata_o = sns_q;
        REG_MODE: rdata_o = mode_q;
        REG_MSK:  rdata_o = msk;
        REG_VEC:  rdata_o = vec;
        REG_SPR:  rdata_o = spr_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_GATED_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (!crit_o && !ncrit_o)); // R7
  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_EN) |=> (en_q == $past(wdata_i))); // R11
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk != '0) |-> (vec < NUM_SRC)); // R9
  AST_VEC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk == '0) |-> (vec == '1)); // R9
endmodule

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        crit_o, ncrit_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_ctrl_top u0 (.*);

  // behavioural reference, indexed by line number
  bit m_s1[32], m_s2[32], m_prev[32], m_pend[32];
  bit m_en[32], m_rout[32], m_sns[32], m_mode[32];
  logic [31:0] m_spr;

  function automatic logic [31:0] pack(input bit a[32]);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[31-n] = a[n];
    return r;
  endfunction

  function automatic logic [31:0] m_vec();
    for (int n = 0; n < 32; n++) if (m_pend[n] && m_en[n]) return n;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit m_req(input bit want_crit);
    bit r = 0;
    for (int n = 0; n < 32; n++)
      if (m_pend[n] && m_en[n] && (m_rout[n] == want_crit)) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] r;
    case (a)
      4'h0: r = pack(m_pend);
      4'h2: r = pack(m_en);
      4'h3: r = pack(m_rout);
      4'h4: r = pack(m_sns);
      4'h5: r = pack(m_mode);
      4'h6: r = pack(m_pend) & pack(m_en);
      4'h7: r = m_vec();
      4'h8: r = m_spr;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < 32; n++) begin
        m_s1[n] = 0; m_s2[n] = 0; m_prev[n] = 0; m_pend[n] = 0;
        m_en[n] = 0; m_rout[n] = 0; m_sns[n] = 1; m_mode[n] = 0;
      end
      m_spr = '0;
    end else begin
      for (int n = 0; n < 32; n++) begin
        bit act, hit, wipe;
        act  = (m_s2[n] == m_sns[n]);
        hit  = m_mode[n] ? (act && m_s2[n] != m_prev[n]) : act;
        wipe = wr_i && addr_i == 4'h0 && wdata_i[31-n];
        m_pend[n] = (m_pend[n] && !wipe) || hit;
        m_prev[n] = m_s2[n];
        m_s2[n]   = m_s1[n];
        m_s1[n]   = src_i[n];
      end
      if (wr_i) begin
        for (int n = 0; n < 32; n++) begin
          case (addr_i)
            4'h2: m_en[n]   = wdata_i[31-n];
            4'h3: m_rout[n] = wdata_i[31-n];
            4'h4: m_sns[n]  = wdata_i[31-n];
            4'h5: m_mode[n] = wdata_i[31-n];
            default: ;
          endcase
        end
        if (addr_i == 4'h8) m_spr = wdata_i;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      chk({31'd0, crit_o},  {31'd0, m_req(1)}, "R7 crit_o");
      chk({31'd0, ncrit_o}, {31'd0, m_req(0)}, "R7 ncrit_o");
      chk(rdata_o, rd_i ? m_read(addr_i) : 32'h0, "R10 rdata_o");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_lit(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 chk(rdata_o, exp, tag);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk_i); src_i[n] = 1'b1;
    @(negedge clk_i); src_i[n] = 1'b0;
    idle(4);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL WDOG run hung act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    rd_lit(4'h0, 32'h0, "R1 pend");
    rd_lit(4'h2, 32'h0, "R1 en");
    rd_lit(4'h3, 32'h0, "R1 rout");
    rd_lit(4'h4, 32'hFFFF_FFFF, "R1 sns");
    rd_lit(4'h5, 32'h0, "R1 mode");
    rd_lit(4'h7, 32'hFFFF_FFFF, "R1 vec");
    chk({30'd0, crit_o, ncrit_o}, 32'h0, "R1 requests");
    // R10 undefined offsets
    rd_lit(4'h1, 32'h0, "R10 off1");
    rd_lit(4'h9, 32'h0, "R10 off9");
    rd_lit(4'hF, 32'h0, "R10 offF");

    // lines 0..15 edge, line 4 falling, line 3 critical, all enabled
    wr(4'h5, 32'hFFFF_0000);
    wr(4'h4, 32'hFFFF_FFFF & ~(32'h1 << 27));
    wr(4'h3, 32'h1 << 28);
    wr(4'h2, 32'hFFFF_FFFF);
    idle(3);
    rd_lit(4'h0, 32'h0, "R8 sense write no event");

    pulse(2);
    rd_lit(4'h0, 32'h2000_0000, "R2 R3 rising edge line 2");
    rd_lit(4'h7, 32'd2, "R9 vec line 2");
    chk({30'd0, crit_o, ncrit_o}, 32'h1, "R7 normal request");

    pulse(3);
    rd_lit(4'h0, 32'h3000_0000, "R3 line 3");
    chk({30'd0, crit_o, ncrit_o}, 32'h3, "R7 both requests");
    rd_lit(4'h7, 32'd2, "R9 lowest wins");

    wr(4'h0, 32'h0);
    rd_lit(4'h0, 32'h3000_0000, "R5 zero write keeps");
    wr(4'h0, 32'h2000_0000);
    rd_lit(4'h0, 32'h1000_0000, "R5 one clears");
    rd_lit(4'h7, 32'd3, "R9 next line");

    @(negedge clk_i); src_i[4] = 1'b1; idle(4);
    rd_lit(4'h0, 32'h1000_0000, "R3 falling mode ignores rise");
    @(negedge clk_i); src_i[4] = 1'b0; idle(4);
    rd_lit(4'h0, 32'h1800_0000, "R3 falling edge line 4");
    wr(4'h0, 32'hFFFF_FFFF);
    rd_lit(4'h0, 32'h0, "R5 clear all");

    // level line 20 (bit 11)
    @(negedge clk_i); src_i[20] = 1'b1; idle(4);
    rd_lit(4'h0, 32'h0000_0800, "R4 level sets");
    wr(4'h2, 32'hFFFF_F7FF);
    wr(4'h0, 32'h0000_0800);
    rd_lit(4'h0, 32'h0000_0800, "R4 clear ignored while active disabled");
    rd_lit(4'h6, 32'h0, "R6 masked hides disabled");
    rd_lit(4'h7, 32'hFFFF_FFFF, "R9 none pending");
    chk({30'd0, crit_o, ncrit_o}, 32'h0, "R7 no request");
    @(negedge clk_i); src_i[20] = 1'b0; idle(4);
    wr(4'h0, 32'h0000_0800);
    rd_lit(4'h0, 32'h0, "R4 clear after release");

    // edge latches while disabled (line 7, bit 24)
    wr(4'h2, 32'hFFFF_F7FF & ~(32'h1 << 24));
    pulse(7);
    rd_lit(4'h0, 32'h0100_0000, "R6 latch while disabled");
    rd_lit(4'h6, 32'h0, "R6 masked zero");
    wr(4'h0, 32'hFFFF_FFFF);

    // config changes on line 5 (bit 26)
    @(negedge clk_i); src_i[5] = 1'b1; idle(4);
    wr(4'h0, 32'h0400_0000);
    wr(4'h4, 32'hFFFF_FFFF & ~(32'h1 << 27) & ~(32'h1 << 26));
    idle(3);
    rd_lit(4'h0, 32'h0, "R8 sense flip no event");
    wr(4'h5, 32'hFFFF_0000 & ~(32'h1 << 26));
    idle(3);
    rd_lit(4'h0, 32'h0, "R8 mode flip inactive level");
    @(negedge clk_i); src_i[5] = 1'b0; idle(4);
    rd_lit(4'h0, 32'h0400_0000, "R4 active low level");

    // spare and read-only offsets
    wr(4'h8, 32'h1234_5678);
    rd_lit(4'h8, 32'h1234_5678, "R10 spare");
    wr(4'h6, 32'hFFFF_FFFF);
    rd_lit(4'h6, 32'h0400_0000, "R10 masked write ignored");
    wr(4'h7, 32'h0);
    rd_lit(4'h7, 32'd5, "R10 vec write ignored");
    @(negedge clk_i); addr_i = 4'h8; rd_i = 1'b0;
    #1 chk(rdata_o, 32'h0, "R10 no strobe");

    // same-cycle write and read
    @(negedge clk_i);
    addr_i = 4'h2; wdata_i = 32'hA5A5_0000; wr_i = 1'b1; rd_i = 1'b1;
    #1 chk(rdata_o, 32'hFFFF_F7FF & ~(32'h1 << 24), "R11 old value");
    @(posedge clk_i); #1 chk(rdata_o, 32'hA5A5_0000, "R11 new value");
    @(negedge clk_i); wr_i = 1'b0; rd_i = 1'b0;
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule